// File: doc/BRIEF.md
# Dual-Clock FIFO with Bounded Flag Latency

This block is a first-in first-out buffer whose two ports run on unrelated clocks. The producer writes words on its own clock and watches a full flag. The consumer pulls words on its own clock and watches an empty flag. Read data is registered: a word appears on the output one read-clock cycle after the read request that took it, and it holds until the next accepted read.

Each port keeps a binary position counter and a Gray-coded copy of it. Only the Gray copy crosses into the other clock domain, through a chain of `SYNC_STAGES` flops. Each flag is registered in its own domain and computed from the local next position and the synchronized remote one. This fixes how long a flag takes to react to activity on the far side. One storage slot is always left unused, so a buffer built with `CFG_DEPTH` slots holds `CFG_DEPTH-1` words.

When the read clock is much faster than the write clock, a full buffer that is read without pause can become empty before the full flag has dropped. The block treats this as a legal state and leaves its positions intact. A write refused because the buffer is full, or a read refused because it is empty, is dropped and reported by a one-cycle pulse in the domain where it was attempted. Each domain's reset input is synchronized locally before use.

Top module: `xclk_fifo`

## Requirements
- R1: While a domain's synchronized reset is active, and once it releases: `rd_empty` is 1, `wr_full` is 0, both pulse outputs are 0, and `rd_data` is 0.
- R2: Words leave in the order they entered. After the read-clock edge that accepts `rd_en` while `rd_empty` is 0, `rd_data` shows the next word, and it keeps that value until the next accepted read.
- R3: Starting from empty with no reads, `wr_full` rises in the write cycle right after the edge that stores word number `CFG_DEPTH-1`, and stays 0 before that.
- R4: A write presented while `wr_full` is 1 stores nothing. `wr_overflow` is 1 for exactly the following write cycle, and is 0 after any cycle without such an attempt.
- R5: A read presented while `rd_empty` is 1 consumes nothing and leaves `rd_data` unchanged. `rd_underflow` is 1 for exactly the following read cycle.
- R6: `wr_full` is conservative. It is never 0 while the buffer holds `CFG_DEPTH-1` words.
- R7: `rd_empty` is conservative. It is never 0 while the buffer holds no word, and it rises in the read cycle right after the edge that takes the last word.
- R8: After a read from a full buffer, `wr_full` falls no later than one read-clock period plus (3+`SYNC_STAGES`) write-clock periods after the accepting read edge.
- R9: After a write into an empty buffer, `rd_empty` falls no later than one write-clock period plus (3+`SYNC_STAGES`) read-clock periods after the accepting write edge.
- R10: With a fast read clock, a continuously read full buffer may show `wr_full` and `rd_empty` both at 1. Afterwards, traffic continues with correct ordering and the flags settle to empty and not full.
- R11: The position value sent across domains changes in at most one bit per local clock cycle, and in exactly one bit after each accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_in | input | 1 | Write-side reset request, active high, synchronized internally |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room for another word (conservative) |
| wr_overflow | output | 1 | One-cycle pulse after a refused write |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_in | input | 1 | Read-side reset request, active high, synchronized internally |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| rd_empty | output | 1 | No word available (conservative) |
| rd_underflow | output | 1 | One-cycle pulse after a refused read |

## Verification
A corrupted position counter or a wrong Gray encoding shows up at the ports as a skipped, repeated or stale word on `rd_data`. The reference queue catches it on the first read past the fault, and in a full-buffer test that can come within a handful of read cycles. A flag computed from the wrong comparison shows up as a flag that clears while the model says there is no room or no data, and this is checked on every edge of the flag's own clock. A synchronizer chain that is too long, or a flag that is registered too late, appears as a flag transition measured beyond its time budget at either of two clock ratios, one of them write-slow/read-fast.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;

    // Which port a position keeper serves; selects the flag rule.
    typedef enum logic {
        SIDE_WRITE = 1'b0,
        SIDE_READ  = 1'b1
    } side_e;

    // Per-domain registered status: the flag and the refused-access pulse.
    typedef struct packed {
        logic flag;
        logic err;
    } side_status_t;

    // Position width: one bit beyond the slot index, so the modular
    // difference of two positions covers every occupancy.
    function automatic int ptr_bits(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/xclk_rst_sync.sv
`timescale 1ns/1ps
module xclk_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    // Assert at once on request, release after STAGES local edges.
    always_ff @(posedge clk) begin
        if (rst_in) chain <= '1;
        else        chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/xclk_gray_sync.sv
`timescale 1ns/1ps
module xclk_gray_sync #(
    parameter int W = 6,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage [N];

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage[s] <= '0;
                else if (s == 0) stage[s] <= gray_in;
                else             stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Gray to binary: bit i is the XOR of all Gray bits at i and above.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stage[N-1] >> i);
        end
    end
endmodule

// File: rtl/xclk_side.sv
`timescale 1ns/1ps
module xclk_side
    import xclk_fifo_pkg::*;
#(
    parameter int    DEPTH = 20,
    parameter side_e KIND  = SIDE_WRITE,
    localparam int   PW    = ptr_bits(DEPTH),
    localparam int   AW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [PW-1:0] remote_bin,
    output logic [PW-1:0] ptr_gray,
    output logic [AW-1:0] addr,
    output logic          fire,
    output side_status_t  status
);
    logic [PW-1:0] bin_q;
    logic [PW-1:0] bin_nx;
    logic [AW-1:0] addr_q;
    logic          flag_nx;

    assign fire   = req && !status.flag;
    assign bin_nx = bin_q + PW'(fire);
    assign addr   = addr_q;

    generate
        if (KIND == SIDE_WRITE) begin : g_full
            logic [PW-1:0] occ;
            assign occ     = bin_nx - remote_bin;
            assign flag_nx = (occ >= PW'(DEPTH - 1));
        end else begin : g_empty
            assign flag_nx = (bin_nx == remote_bin);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q       <= '0;
            addr_q      <= '0;
            ptr_gray    <= '0;
            status.flag <= (KIND == SIDE_READ);
            status.err  <= 1'b0;
        end else begin
            bin_q       <= bin_nx;
            ptr_gray    <= bin_nx ^ (bin_nx >> 1);
            status.flag <= flag_nx;
            status.err  <= req && status.flag;
            if (fire) addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CFG_DEPTH   = 20,
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_in,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_underflow
);
    localparam int PW = ptr_bits(CFG_DEPTH);
    localparam int AW = $clog2(CFG_DEPTH);

    logic          wrst, rrst;
    logic [PW-1:0] w_gray, r_gray;
    logic [PW-1:0] w_bin_at_rd, r_bin_at_wr;
    logic [AW-1:0] waddr, raddr;
    logic          w_fire, r_fire;
    side_status_t  w_stat, r_stat;
    logic [DATA_W-1:0] mem [CFG_DEPTH];

    xclk_rst_sync #(.STAGES(RST_STAGES)) u_wrst (
        .clk(wr_clk), .rst_in(wr_rst_in), .rst_out(wrst));
    xclk_rst_sync #(.STAGES(RST_STAGES)) u_rrst (
        .clk(rd_clk), .rst_in(rd_rst_in), .rst_out(rrst));

    xclk_side #(.DEPTH(CFG_DEPTH), .KIND(SIDE_WRITE)) u_wside (
        .clk(wr_clk), .rst(wrst), .req(wr_en), .remote_bin(r_bin_at_wr),
        .ptr_gray(w_gray), .addr(waddr), .fire(w_fire), .status(w_stat));
    xclk_side #(.DEPTH(CFG_DEPTH), .KIND(SIDE_READ)) u_rside (
        .clk(rd_clk), .rst(rrst), .req(rd_en), .remote_bin(w_bin_at_rd),
        .ptr_gray(r_gray), .addr(raddr), .fire(r_fire), .status(r_stat));

    xclk_gray_sync #(.W(PW), .N(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wrst), .gray_in(r_gray), .bin_out(r_bin_at_wr));
    xclk_gray_sync #(.W(PW), .N(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rrst), .gray_in(w_gray), .bin_out(w_bin_at_rd));

    always_ff @(posedge wr_clk) begin
        if (w_fire) mem[waddr] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
        if (rrst)        rd_data <= '0;
        else if (r_fire) rd_data <= mem[raddr];
    end

    assign wr_full      = w_stat.flag;
    assign wr_overflow  = w_stat.err;
    assign rd_empty     = r_stat.flag;
    assign rd_underflow = r_stat.err;
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
    parameter int PW     = 6,
    parameter int DATA_W = 8
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wrst,
    input logic              rrst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              wr_full,
    input logic              rd_empty,
    input logic              wr_overflow,
    input logic              rd_underflow,
    input logic [PW-1:0]     w_gray,
    input logic [PW-1:0]     r_gray,
    input logic [DATA_W-1:0] rd_data
);
    assert_reset_full_R1: assert property (@(posedge wr_clk)
        (wrst === 1'b1) |=> (!wr_full && !wr_overflow));

    assert_reset_empty_R1: assert property (@(posedge rd_clk)
        (rrst === 1'b1) |=> (rd_empty && !rd_underflow && rd_data == '0));

    assert_overflow_pulse_R4: assert property (@(posedge wr_clk) disable iff (wrst !== 1'b0)
        (wr_en && wr_full) |=> (wr_overflow && $stable(w_gray)));

    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (wrst !== 1'b0)
        !(wr_en && wr_full) |=> !wr_overflow);

    assert_underflow_pulse_R5: assert property (@(posedge rd_clk) disable iff (rrst !== 1'b0)
        (rd_en && rd_empty) |=> (rd_underflow && $stable(r_gray) && $stable(rd_data)));

    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (rrst !== 1'b0)
        !(rd_en && rd_empty) |=> !rd_underflow);

    assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (wrst !== 1'b0)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (rrst !== 1'b0)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    assert_wgray_advance_R11: assert property (@(posedge wr_clk) disable iff (wrst !== 1'b0)
        (wr_en && !wr_full) |=> ($countones(w_gray ^ $past(w_gray)) == 1));

    assert_rgray_advance_R11: assert property (@(posedge rd_clk) disable iff (rrst !== 1'b0)
        (rd_en && !rd_empty) |=> ($countones(r_gray ^ $past(r_gray)) == 1));
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(PW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
    localparam int DW     = 8;
    localparam int DEPTH  = 20;
    localparam int NS     = 2;
    localparam int USABLE = DEPTH - 1;

    real wr_half = 2.5;
    real rd_half = 2.5;
    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #(wr_half) wclk = ~wclk;
    always #(rd_half) rclk = ~rclk;

    logic          wr_rst_in = 1'b1, rd_rst_in = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, wr_overflow, rd_empty, rd_underflow;

    xclk_fifo #(.DATA_W(DW), .CFG_DEPTH(DEPTH), .SYNC_STAGES(NS)) uut (
        .wr_clk(wclk), .wr_rst_in(wr_rst_in), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_overflow(wr_overflow),
        .rd_clk(rclk), .rd_rst_in(rd_rst_in), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_underflow(rd_underflow));

    int compared = 0;
    int mismatched = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: a queue of accepted words.
    logic [DW-1:0] model_q [$];
    int  wr_total = 0, rd_total = 0;
    bit  active = 0;
    bit  wr_on = 0, wr_force = 0, wr_single = 0, fill_watch = 0;
    bit  rd_on = 0, rd_force = 0, rd_single = 0;
    bit  seen_both = 0;
    real t_wr_edge = 0.0, t_rd_edge = 0.0;

    function automatic logic [DW-1:0] gen(input int n);
        return DW'(n * 37 + 11);
    endfunction

    // Write domain: compare, then drive, on the falling edge.
    bit exp_ovf = 0;
    always @(negedge wclk) begin
        if (!active) begin
            wr_en = 1'b0;
            exp_ovf = 0;
        end else begin
            check(wr_overflow == exp_ovf, "R4", "overflow pulse", wr_overflow, exp_ovf);
            if (!wr_full)
                check(model_q.size() < USABLE, "R6", "full low with no room", model_q.size(), USABLE - 1);
            if (fill_watch)
                check(wr_full == (model_q.size() >= USABLE), "R3", "full vs stored words",
                      wr_full, model_q.size() >= USABLE);
            exp_ovf = 0;
            wr_en = 1'b0;
            if ((wr_on && !wr_full) || wr_force || (wr_single && !wr_full)) begin
                wr_en = 1'b1;
                wr_data = gen(wr_total);
                if (!wr_full) begin
                    model_q.push_back(wr_data);
                    wr_total++;
                    if (wr_single) begin
                        t_wr_edge = $realtime + wr_half;
                        wr_single = 0;
                    end
                end else begin
                    exp_ovf = 1;
                end
            end
        end
    end

    // Read domain: compare, then drive, on the falling edge.
    bit rd_pend = 0, exp_unf = 0;
    logic [DW-1:0] exp_data = '0;
    always @(negedge rclk) begin
        if (!active) begin
            rd_en = 1'b0;
            rd_pend = 0;
            exp_unf = 0;
            exp_data = '0;
        end else begin
            check(rd_underflow == exp_unf, "R5", "underflow pulse", rd_underflow, exp_unf);
            if (rd_pend)
                check(rd_data == exp_data, "R2", "read word order", rd_data, exp_data);
            else
                check(rd_data == exp_data, "R5", "read data held", rd_data, exp_data);
            if (!rd_empty)
                check(model_q.size() > 0, "R7", "empty low with no data", model_q.size(), 1);
            if (wr_full && rd_empty) seen_both = 1;
            rd_pend = 0;
            exp_unf = 0;
            rd_en = 1'b0;
            if ((rd_on && !rd_empty) || rd_force || (rd_single && !rd_empty)) begin
                rd_en = 1'b1;
                if (!rd_empty) begin
                    if (model_q.size() > 0) exp_data = model_q.pop_front();
                    rd_pend = 1;
                    rd_total++;
                    if (rd_single) begin
                        t_rd_edge = $realtime + rd_half;
                        rd_single = 0;
                    end
                end else begin
                    exp_unf = 1;
                end
            end
        end
    end

    task automatic run_ratio(input real wp, input real rp, input bit expect_both);
        real lat, bound;
        int  target;
        @(posedge rclk);
        active = 0;
        wr_on = 0; wr_force = 0; wr_single = 0; fill_watch = 0;
        rd_on = 0; rd_force = 0; rd_single = 0;
        wr_half = wp / 2.0;
        rd_half = rp / 2.0;
        wr_rst_in = 1'b1;
        rd_rst_in = 1'b1;
        model_q.delete();
        wr_total = 0;
        rd_total = 0;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        wr_rst_in = 1'b0;
        rd_rst_in = 1'b0;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);

        // R1: state after reset release
        @(negedge rclk);
        check(rd_empty == 1'b1, "R1", "empty after reset", rd_empty, 1);
        check(rd_underflow == 1'b0, "R1", "underflow after reset", rd_underflow, 0);
        check(rd_data == '0, "R1", "read data after reset", rd_data, 0);
        @(negedge wclk);
        check(wr_full == 1'b0, "R1", "full after reset", wr_full, 0);
        check(wr_overflow == 1'b0, "R1", "overflow after reset", wr_overflow, 0);
        @(posedge rclk) active = 1;

        // R5: reads on an empty buffer
        @(posedge rclk) rd_force = 1;
        repeat (3) @(posedge rclk);
        rd_force = 0;
        repeat (3) @(posedge rclk);

        // R3: fill to capacity
        @(posedge wclk) begin fill_watch = 1; wr_on = 1; end
        wait (wr_total == USABLE);
        @(posedge wclk) wr_on = 0;
        repeat (2) @(posedge wclk);
        @(negedge wclk);
        check(wr_full == 1'b1, "R3", "full after capacity writes", wr_full, 1);

        // R4: writes on a full buffer
        @(posedge wclk) wr_force = 1;
        repeat (3) @(posedge wclk);
        wr_force = 0;
        repeat (3) @(posedge wclk);
        fill_watch = 0;

        // R8: full-clear latency
        @(posedge rclk) rd_single = 1;
        wait (rd_single == 0);
        wait (wr_full == 1'b0);
        lat = $realtime - t_rd_edge;
        bound = rp + (3 + NS) * wp;
        check(lat <= bound, "R8", "full clear latency ps", longint'(lat * 1000.0), longint'(bound * 1000.0));

        // R10: refill, then drain at full speed
        @(posedge wclk) wr_on = 1;
        wait (wr_total == USABLE + 1);
        @(posedge wclk) wr_on = 0;
        repeat (2) @(posedge wclk);
        seen_both = 0;
        @(posedge rclk) rd_on = 1;
        wait (rd_total == wr_total);
        @(posedge rclk) rd_on = 0;
        repeat (8) @(posedge wclk);
        repeat (8) @(posedge rclk);
        if (expect_both)
            check(seen_both == 1, "R10", "full and empty seen together", seen_both, 1);
        @(negedge wclk);
        check(wr_full == 1'b0, "R10", "full settled low", wr_full, 0);
        @(negedge rclk);
        check(rd_empty == 1'b1, "R7", "empty after last read", rd_empty, 1);

        // R9: empty-clear latency
        @(posedge wclk) wr_single = 1;
        wait (wr_single == 0);
        wait (rd_empty == 1'b0);
        lat = $realtime - t_wr_edge;
        bound = wp + (3 + NS) * rp;
        check(lat <= bound, "R9", "empty clear latency ps", longint'(lat * 1000.0), longint'(bound * 1000.0));
        @(posedge rclk) rd_on = 1;
        wait (rd_total == wr_total);
        @(posedge rclk) rd_on = 0;

        // R2: concurrent streaming traffic
        target = wr_total + 60;
        @(posedge wclk) wr_on = 1;
        @(posedge rclk) rd_on = 1;
        wait (wr_total >= target);
        @(posedge wclk) wr_on = 0;
        wait (rd_total == wr_total);
        repeat (4) @(posedge rclk);
        rd_on = 0;
        repeat (8) @(posedge wclk);
        check(rd_total == wr_total, "R2", "words read vs written", rd_total, wr_total);
        @(posedge rclk) active = 0;
    endtask

    initial begin
        fork
            begin
                // Write clock at 3/148 of the 200 MHz read clock.
                run_ratio(5.0 * 148.0 / 3.0, 5.0, 1'b1);
                // 200 MHz write clock against a slower read clock.
                run_ratio(5.0, 12.0, 1'b0);
            end
            begin
                #500000;
                check(0, "watchdog", "run did not complete", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule